// File: doc/BRIEF.md
# Event-Condition-Action Rule Engine

The block steers memory traffic without a program counter. It holds a small table of rules over a bank of 64 named value queues. Each rule names a primary trigger queue, an optional second trigger queue, an optional condition and an action. In each cycle every rule whose triggers all hold data, whose condition is met and whose resources are free is marked ready. The lowest-numbered ready rule then fires. Firing pops its trigger queues and performs a load, a store or a move.

Loads and stores go out on a request port with a valid/ready handshake. Load data comes back on a response port. A tag FIFO records the destination queue of every load that has issued, so each returned word goes to the queue of the load it answers, in issue order. A host-side port lets the surrounding logic push values into any queue and pop any queue's head. The compute nodes use this port to feed addresses and to collect results. Rules are written one at a time through a configuration port.

Top module: `ecarule_engine`

## Requirements
- R1: After reset every queue is empty (`out_valid` low for any `out_q`), no rule is enabled, `req_valid` is low and `in_ready` is high.
- R2: A rule with only a primary trigger fires as soon as that queue holds data, and it pops exactly one entry from that queue.
- R3: A rule with `useb` set does not fire while either of its two trigger queues is empty. Data in the non-empty queue stays in place.
- R4: When `cond` is set, the rule fires only if the head of the second trigger queue is nonzero. While that head is zero, both trigger queues keep their heads.
- R5: A load (op 0) presents the primary queue's head on `req_addr` with `req_we` low. The data later accepted on the response port is pushed into the rule's destination queue.
- R6: Load responses are delivered in issue order, each to the destination queue of the load it answers.
- R7: A store (op 1, `useb` required) presents the primary queue's head as `req_addr` and the second queue's head as `req_wdata`, with `req_we` high.
- R8: A move (op 2) copies the primary queue's head into the destination queue when `dst_en` is set. With `dst_en` clear, it only consumes its trigger queues.
- R9: A rule whose destination queue is full does not fire, and its trigger data stays queued until room appears.
- R10: When several rules are ready, the lowest-numbered rule fires, and at most one action issues per cycle.
- R11: Each queue is a 4-entry FIFO. `in_ready` is low for a full queue, and values leave in the order they entered.
- R12: While `req_ready` is low, no load or store fires, and its trigger queues are not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write the rule at `cfg_idx` |
| cfg_idx | input | 3 | Rule slot to write |
| cfg_en | input | 1 | Rule enabled |
| cfg_op | input | 2 | Action: 0 load, 1 store, 2 move |
| cfg_qa | input | 6 | Primary trigger queue (address or move source) |
| cfg_qb | input | 6 | Second trigger queue (store data or condition) |
| cfg_useb | input | 1 | Second trigger queue is part of the trigger |
| cfg_cond | input | 1 | Require a nonzero head on the second queue |
| cfg_dst | input | 6 | Destination queue for load or move |
| cfg_dst_en | input | 1 | Move writes the destination queue |
| in_we | input | 1 | Host push request |
| in_q | input | 6 | Queue to push |
| in_data | input | 16 | Value to push |
| in_ready | output | 1 | Push on `in_q` is accepted this cycle |
| out_q | input | 6 | Queue to observe |
| out_pop | input | 1 | Pop the observed queue |
| out_valid | output | 1 | Observed queue has a head the host may take |
| out_data | output | 16 | Head of the observed queue |
| req_valid | output | 1 | Memory request issued |
| req_ready | input | 1 | Memory accepts a request |
| req_we | output | 1 | Request is a store |
| req_addr | output | 16 | Request address |
| req_wdata | output | 16 | Store data |
| rsp_valid | input | 1 | Load data available |
| rsp_ready | output | 1 | Engine accepts load data |
| rsp_data | input | 16 | Load data |

## Verification
The assertions rely on several assumptions about the environment:
- Memory returns data only while a load is still outstanding.
- No rule names the same queue as both of its triggers.
- The host pops a queue only while `out_valid` is high.

The bench keeps within these limits. It raises `rsp_valid` only after it has counted issued loads in its own request log, and it supplies exactly that many responses. It gives every rule distinct trigger queues. Its pop task drives `out_pop` only from a sampled `out_valid`.

// File: rtl/ecarule_engine.sv
module ecarule_engine #(
  parameter int QN = 64,
  parameter int QD = 4,
  parameter int DW = 16,
  parameter int RN = 8,
  parameter int TD = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(RN)-1:0]  cfg_idx,
  input  logic                   cfg_en,
  input  logic [1:0]             cfg_op,
  input  logic [$clog2(QN)-1:0]  cfg_qa,
  input  logic [$clog2(QN)-1:0]  cfg_qb,
  input  logic                   cfg_useb,
  input  logic                   cfg_cond,
  input  logic [$clog2(QN)-1:0]  cfg_dst,
  input  logic                   cfg_dst_en,
  input  logic                   in_we,
  input  logic [$clog2(QN)-1:0]  in_q,
  input  logic [DW-1:0]          in_data,
  output logic                   in_ready,
  input  logic [$clog2(QN)-1:0]  out_q,
  input  logic                   out_pop,
  output logic                   out_valid,
  output logic [DW-1:0]          out_data,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic                   req_we,
  output logic [DW-1:0]          req_addr,
  output logic [DW-1:0]          req_wdata,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [DW-1:0]          rsp_data
);
  localparam int QW = $clog2(QN);
  localparam int PW = $clog2(QD);
  localparam int RW = $clog2(RN);
  localparam int TW = $clog2(TD);
  localparam logic [1:0] OP_LD = 2'd0;
  localparam logic [1:0] OP_ST = 2'd1;
  localparam logic [1:0] OP_MV = 2'd2;

  logic          r_en   [RN];
  logic [1:0]    r_op   [RN];
  logic [QW-1:0] r_qa   [RN];
  logic [QW-1:0] r_qb   [RN];
  logic [QW-1:0] r_dst  [RN];
  logic          r_useb [RN];
  logic          r_cond [RN];
  logic          r_dsten[RN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RN; i++) begin
        r_en[i] <= 1'b0;   r_op[i] <= '0;     r_qa[i] <= '0;    r_qb[i] <= '0;
        r_dst[i] <= '0;    r_useb[i] <= 1'b0; r_cond[i] <= 1'b0; r_dsten[i] <= 1'b0;
      end
    end else if (cfg_we) begin
      r_en[cfg_idx]    <= cfg_en;
      r_op[cfg_idx]    <= cfg_op;
      r_qa[cfg_idx]    <= cfg_qa;
      r_qb[cfg_idx]    <= cfg_qb;
      r_dst[cfg_idx]   <= cfg_dst;
      r_useb[cfg_idx]  <= cfg_useb;
      r_cond[cfg_idx]  <= cfg_cond;
      r_dsten[cfg_idx] <= cfg_dst_en;
    end
  end

  logic [DW-1:0] qmem [QN][QD];
  logic [PW-1:0] qrp  [QN];
  logic [PW-1:0] qwp  [QN];
  logic [PW:0]   qcnt [QN];
  logic [QN-1:0] q_empty, q_full, q_push, q_pop;
  logic [DW-1:0] q_head  [QN];
  logic [DW-1:0] q_pdata [QN];

  always_comb begin
    for (int q = 0; q < QN; q++) begin
      q_empty[q] = (qcnt[q] == '0);
      q_full[q]  = (qcnt[q] == (PW+1)'(QD));
      q_head[q]  = qmem[q][qrp[q]];
    end
  end

  logic [QW-1:0] tmem [TD];
  logic [TW-1:0] trp, twp;
  logic [TW:0]   tcnt;
  logic [QW-1:0] tdst;
  logic          t_full, rsp_acc;

  assign tdst      = tmem[trp];
  assign t_full    = (tcnt == (TW+1)'(TD));
  assign rsp_ready = (tcnt != '0) && !q_full[tdst];
  assign rsp_acc   = rsp_valid && rsp_ready;

  logic [RN-1:0] rdy;
  logic [RW-1:0] sel;
  logic          fire;

  always_comb begin
    for (int i = 0; i < RN; i++) begin
      rdy[i] = r_en[i] && !q_empty[r_qa[i]]
            && (!r_useb[i] || !q_empty[r_qb[i]])
            && (!r_cond[i] || (r_useb[i] && q_head[r_qb[i]] != '0));
      case (r_op[i])
        OP_LD:   rdy[i] = rdy[i] && req_ready && !t_full && !q_full[r_dst[i]];
        OP_ST:   rdy[i] = rdy[i] && req_ready && r_useb[i];
        OP_MV:   rdy[i] = rdy[i] && (!r_dsten[i] ||
                          (!q_full[r_dst[i]] && !(rsp_acc && tdst == r_dst[i])));
        default: rdy[i] = 1'b0;
      endcase
    end
    sel = '0;
    for (int i = RN - 1; i >= 0; i--)
      if (rdy[i]) sel = RW'(i);
  end

  assign fire = |rdy;

  logic [1:0]    s_op;
  logic [QW-1:0] s_qa, s_qb, s_dst;
  logic          s_useb, is_ld, is_st, mv_push;

  assign s_op    = r_op[sel];
  assign s_qa    = r_qa[sel];
  assign s_qb    = r_qb[sel];
  assign s_dst   = r_dst[sel];
  assign s_useb  = r_useb[sel];
  assign is_ld   = fire && s_op == OP_LD;
  assign is_st   = fire && s_op == OP_ST;
  assign mv_push = fire && s_op == OP_MV && r_dsten[sel];

  assign req_valid = is_ld || is_st;
  assign req_we    = is_st;
  assign req_addr  = q_head[s_qa];
  assign req_wdata = is_st ? q_head[s_qb] : '0;

  assign in_ready  = !q_full[in_q] && !(rsp_acc && tdst == in_q) && !(mv_push && s_dst == in_q);
  assign out_valid = !q_empty[out_q] && !(fire && (out_q == s_qa || (s_useb && out_q == s_qb)));
  assign out_data  = q_head[out_q];

  always_comb begin
    for (int q = 0; q < QN; q++) begin
      q_pop[q] = (fire && s_qa == QW'(q)) || (fire && s_useb && s_qb == QW'(q))
              || (out_pop && out_valid && out_q == QW'(q));
      q_push[q]  = 1'b0;
      q_pdata[q] = in_data;
      if (rsp_acc && tdst == QW'(q)) begin
        q_push[q] = 1'b1;  q_pdata[q] = rsp_data;
      end else if (mv_push && s_dst == QW'(q)) begin
        q_push[q] = 1'b1;  q_pdata[q] = q_head[s_qa];
      end else if (in_we && in_ready && in_q == QW'(q)) begin
        q_push[q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < QN; q++)
      if (q_push[q]) qmem[q][qwp[q]] <= q_pdata[q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < QN; q++) begin
        qrp[q] <= '0;  qwp[q] <= '0;  qcnt[q] <= '0;
      end
    end else begin
      for (int q = 0; q < QN; q++) begin
        if (q_push[q]) qwp[q] <= qwp[q] + 1'b1;
        if (q_pop[q])  qrp[q] <= qrp[q] + 1'b1;
        qcnt[q] <= qcnt[q] + (PW+1)'(q_push[q]) - (PW+1)'(q_pop[q]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (is_ld) tmem[twp] <= s_dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trp <= '0;  twp <= '0;  tcnt <= '0;
    end else begin
      if (is_ld)   twp <= twp + 1'b1;
      if (rsp_acc) trp <= trp + 1'b1;
      tcnt <= tcnt + (TW+1)'(is_ld) - (TW+1)'(rsp_acc);
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push & q_full) == '0);
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & q_empty) == '0);
  a_r12_req_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_ready);
  a_r6_load_tag_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !rsp_acc) |=> tcnt == (TW+1)'($past(tcnt) + 1'b1));
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, mv_push}));
endmodule

// File: tb/ecarule_engine_test.sv
`timescale 1ns/1ps
module ecarule_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_we = 0, cfg_en = 0, cfg_useb = 0, cfg_cond = 0, cfg_dst_en = 0;
  logic [2:0] cfg_idx = 0;
  logic [1:0] cfg_op = 0;
  logic [5:0] cfg_qa = 0, cfg_qb = 0, cfg_dst = 0, in_q = 0, out_q = 0;
  logic in_we = 0, out_pop = 0, req_ready = 0, rsp_valid = 0;
  logic [15:0] in_data = 0, rsp_data = 0;
  logic in_ready, out_valid, req_valid, req_we, rsp_ready;
  logic [15:0] out_data, req_addr, req_wdata;

  ecarule_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_op(cfg_op), .cfg_qa(cfg_qa), .cfg_qb(cfg_qb), .cfg_useb(cfg_useb),
    .cfg_cond(cfg_cond), .cfg_dst(cfg_dst), .cfg_dst_en(cfg_dst_en),
    .in_we(in_we), .in_q(in_q), .in_data(in_data), .in_ready(in_ready),
    .out_q(out_q), .out_pop(out_pop), .out_valid(out_valid), .out_data(out_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  int total = 0, bad = 0, lcount = 0;
  bit done = 0;
  logic [15:0] laddr [8];
  logic [15:0] ldata [8];
  logic        lwe   [8];

  always @(posedge clk)
    if (rst_n && req_valid && req_ready && lcount < 8) begin
      laddr[lcount] <= req_addr; ldata[lcount] <= req_wdata; lwe[lcount] <= req_we;
      lcount <= lcount + 1;
    end

  // {condition value, data value, expected to fire}
  localparam logic [32:0] VEC [5] = '{
    {16'h0001, 16'h0011, 1'b1}, {16'h0000, 16'h0022, 1'b0},
    {16'h8000, 16'h0033, 1'b1}, {16'h0000, 16'h0044, 1'b0},
    {16'h0007, 16'h0055, 1'b1}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rule(input int idx, input bit en, input logic [1:0] op, input int qa,
                      input int qb, input bit useb, input bit cond, input int dst, input bit dsten);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_op = op; cfg_qa = 6'(qa);
    cfg_qb = 6'(qb); cfg_useb = useb; cfg_cond = cond; cfg_dst = 6'(dst); cfg_dst_en = dsten;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(input int q, input logic [15:0] d);
    @(negedge clk);
    in_q = 6'(q); in_data = d; in_we = 1;
    @(negedge clk);
    in_we = 0;
  endtask

  task automatic peek(input int q, output logic v, output logic [15:0] d);
    @(negedge clk);
    out_q = 6'(q);
    #1; v = out_valid; d = out_data;
  endtask

  task automatic pop(input int q, output logic v, output logic [15:0] d);
    @(negedge clk);
    out_q = 6'(q);
    #1; v = out_valid; d = out_data; out_pop = v;
    @(negedge clk);
    out_pop = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic v;
    logic [15:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    peek(0, v, d);
    chk("R1 queue empty after reset", v, 0);
    chk("R1 no request after reset", req_valid, 0);
    chk("R1 push ready after reset", in_ready, 1);

    rule(0, 1, 2'd2, 3, 5, 1, 1, 4, 1);
    for (int k = 0; k < 5; k++) begin
      push(3, VEC[k][16:1]);
      settle();
      peek(4, v, d);
      chk("R3 no fire with one trigger", v, 0);
      push(5, VEC[k][32:17]);
      settle();
      peek(4, v, d);
      chk("R4 fires only on nonzero condition", v, VEC[k][0]);
      if (VEC[k][0]) begin
        pop(4, v, d);
        chk("R8 move copies value", d, VEC[k][16:1]);
        peek(3, v, d);
        chk("R2 trigger popped", v, 0);
      end else begin
        peek(3, v, d);
        chk("R4 trigger kept while condition false", d, VEC[k][16:1]);
        pop(3, v, d);
        pop(5, v, d);
      end
    end
    rule(0, 0, 2'd2, 3, 5, 1, 1, 4, 1);

    rule(1, 1, 2'd2, 6, 0, 0, 0, 0, 0);
    push(6, 16'h0005);
    settle();
    peek(6, v, d);
    chk("R8 move without destination consumes", v, 0);

    for (int k = 0; k < 4; k++) push(9, 16'h0090 + 16'(k));
    @(negedge clk) in_q = 9;
    #1 chk("R11 in_ready low when full", in_ready, 0);
    for (int k = 0; k < 4; k++) begin
      pop(9, v, d);
      chk("R11 FIFO order", d, 16'h0090 + 16'(k));
    end

    rule(2, 1, 2'd2, 7, 0, 0, 0, 8, 1);
    for (int k = 0; k < 5; k++) push(7, 16'h00A0 + 16'(k));
    settle();
    peek(7, v, d);
    chk("R9 full destination blocks move", {v, d}, {1'b1, 16'h00A4});
    for (int k = 0; k < 5; k++) begin
      pop(8, v, d);
      chk("R9 values arrive after room appears", d, 16'h00A0 + 16'(k));
    end
    rule(1, 0, 2'd2, 6, 0, 0, 0, 0, 0);
    rule(2, 0, 2'd2, 7, 0, 0, 0, 8, 1);

    rule(3, 1, 2'd0, 10, 0, 0, 0, 11, 0);
    rule(4, 1, 2'd0, 12, 0, 0, 0, 13, 0);
    push(10, 16'h0040);
    settle();
    @(negedge clk) #1 chk("R12 no request while not ready", req_valid, 0);
    peek(10, v, d);
    chk("R12 address kept while stalled", {v, d}, {1'b1, 16'h0040});
    push(12, 16'h0050);
    @(negedge clk) req_ready = 1;
    #1 chk("R10 lowest rule issues first", req_addr, 16'h0040);
    chk("R5 load has write enable low", {req_valid, req_we}, 2'b10);
    @(negedge clk) #1 chk("R5 second load address", req_addr, 16'h0050);
    @(negedge clk) req_ready = 0;
    chk("R6 two loads issued", lcount, 2);
    @(negedge clk) rsp_valid = 1; rsp_data = 16'h00A1;
    #1 chk("R6 response accepted", rsp_ready, 1);
    @(negedge clk) rsp_data = 16'h00B2;
    @(negedge clk) rsp_valid = 0;
    settle();
    pop(11, v, d);
    chk("R6 first response to first destination", {v, d}, {1'b1, 16'h00A1});
    pop(13, v, d);
    chk("R6 second response to second destination", {v, d}, {1'b1, 16'h00B2});

    rule(5, 1, 2'd1, 14, 15, 1, 0, 0, 0);
    push(14, 16'h0060);
    push(15, 16'h0077);
    @(negedge clk) req_ready = 1;
    #1 chk("R7 store request", {req_valid, req_we, req_addr, req_wdata},
           {1'b1, 1'b1, 16'h0060, 16'h0077});
    @(negedge clk) req_ready = 0;
    peek(14, v, d);
    chk("R7 store pops address", v, 0);
    chk("R7 logged as store", {lwe[2], laddr[2], ldata[2]}, {1'b1, 16'h0060, 16'h0077});

    rule(6, 1, 2'd2, 16, 0, 0, 0, 17, 1);
    rule(7, 1, 2'd2, 16, 0, 0, 0, 18, 1);
    push(16, 16'h0033);
    settle();
    peek(17, v, d);
    chk("R10 lower rule wins", {v, d}, {1'b1, 16'h0033});
    peek(18, v, d);
    chk("R10 higher rule idle", v, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule